// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low two bits of the address for a four-beat burst on a synchronous memory. A load command takes a start offset from the low address bits. Each advance command then moves one beat through the burst. The counter wraps within the four beats and never carries into the upper address bits. A strap-style order select chooses how the start offset and the beat index combine. In linear order the beat index is added modulo four. In interleaved order the beat index is XORed with the start offset.

The read/write type of the burst is captured when the burst is loaded. It is then held on a flag output for every beat of that burst, whatever the write-enable input does later. An inactive clock enable makes the block ignore the clock edge, so all state holds. Advance commands step the counter without regard to the access type or to any chip selection. Chip selection is decoded outside this block.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, until the first accepted command, `offset_o` is 0 and `burst_wr_o` is 0.
- R2: With `clk_en_n` low, a rising edge with `adv_ld_n` low loads `addr_lo` as the start offset and sets the beat index to 0. From the next cycle, `offset_o` equals the loaded value in either order. This also holds when a load arrives in the middle of a burst.
- R3: With `order_sel` = 0 (linear), `offset_o` equals (start + beat) mod 4.
- R4: With `order_sel` = 1 (interleaved), `offset_o` equals start XOR beat.
- R5: With `clk_en_n` low, a rising edge with `adv_ld_n` high adds one to the beat index modulo 4. After the fourth advance, `offset_o` returns to the start offset and the sequence repeats.
- R6: During an advance, `wr_en_n` and `addr_lo` have no effect on `offset_o` or `burst_wr_o`.
- R7: At a load, `burst_wr_o` becomes 1 if `wr_en_n` was low and 0 if it was high. The value holds through every advance until the next load.
- R8: While `clk_en_n` is high, a clock edge changes neither the start offset, the beat index nor `burst_wr_o`, whatever the other inputs do.
- R9: `order_sel` is not registered. Changing it mid-burst changes `offset_o` in the same cycle, using the stored start offset and beat index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high ignores the edge |
| adv_ld_n | input | 1 | Low loads a new start offset, high advances one beat |
| addr_lo | input | OFS_W | Low address bits taken at a load |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| wr_en_n | input | 1 | Write enable, active low, sampled only at a load |
| offset_o | output | OFS_W | Current burst offset |
| burst_wr_o | output | 1 | 1 when the current burst is a write |

## Verification
The internal state is only the start offset, the beat index and the access-type flag. Any of these that goes wrong shows up on `offset_o` or `burst_wr_o` at the next sampling point, one clock after the edge that corrupted it. Errors in the order mapping appear in the same cycle as an `order_sel` change. A carry that leaks or a wrap that is missing only shows after four advances, so the bench runs each order past a full wrap. A missed stall shows as an offset that moves during a cycle with `clk_en_n` high.

// File: rtl/bseq_pkg.sv
// Package: shared width and order encoding for the burst offset sequencer.
// Assumes a power-of-two burst length so that offsets wrap naturally.
package bseq_pkg;
    localparam int OFS_W_DEF = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
// Module: holds the start offset and the beat index of the current burst.
// A load captures the start offset and clears the beat index. An advance
// adds one to the beat index, which wraps at 2**W with no carry out.
// Assumes clk_en_n gates every state change.
module bseq_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en_n,
    input  logic         adv_ld_n,
    input  logic [W-1:0] addr_lo,
    output logic [W-1:0] start_q,
    output logic [W-1:0] beat_q
);
    logic take_load;
    logic take_step;

    // Decode the command that the current edge carries.
    always_comb begin
        take_load = !clk_en_n && !adv_ld_n;
        take_step = !clk_en_n &&  adv_ld_n;
    end

    // Update the start offset and the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (take_load) begin
            start_q <= addr_lo;
            beat_q  <= '0;
        end else if (take_step) begin
            beat_q  <= beat_q + W'(1);
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
// Module: combines the start offset and the beat index into the output offset.
// Linear order adds them modulo 2**W. Interleaved order XORs them.
// Purely combinational, so the order select takes effect immediately.
module bseq_order_map #(
    parameter int W = 2
) (
    input  logic         order_sel,
    input  logic [W-1:0] start_q,
    input  logic [W-1:0] beat_q,
    output logic [W-1:0] offset
);
    import bseq_pkg::*;

    logic [W-1:0] lin_ofs;
    logic [W-1:0] ilv_ofs;

    // Linear sum, with the carry dropped.
    always_comb lin_ofs = start_q + beat_q;

    // Interleaved order, built bit by bit.
    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign ilv_ofs[b] = start_q[b] ^ beat_q[b];
    end

    // Pick the ordering that the strap selects.
    always_comb begin
        if (burst_order_e'(order_sel) == ORD_INTERLEAVE) offset = ilv_ofs;
        else                                             offset = lin_ofs;
    end
endmodule

// File: rtl/bseq_type_hold.sv
// Module: captures the access type at a load and holds it for the burst.
// Assumes wr_en_n is active low and is meaningful only at a load.
module bseq_type_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en_n,
    input  logic adv_ld_n,
    input  logic wr_en_n,
    output logic is_wr_q
);
    // Latch the type only when a new burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                      is_wr_q <= 1'b0;
        else if (!clk_en_n && !adv_ld_n) is_wr_q <= !wr_en_n;
    end
endmodule

// File: rtl/burst_offset_seq.sv
// Module: top of the burst offset sequencer.
// Drives the low address offset of a burst and the frozen read/write type.
// Assumes a synchronous active-low reset and a strap-style order select.
module burst_offset_seq #(
    parameter int OFS_W = bseq_pkg::OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             adv_ld_n,
    input  logic [OFS_W-1:0] addr_lo,
    input  logic             order_sel,
    input  logic             wr_en_n,
    output logic [OFS_W-1:0] offset_o,
    output logic             burst_wr_o
);
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] beat_q;

    bseq_beat_ctr #(.W(OFS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .adv_ld_n (adv_ld_n),
        .addr_lo  (addr_lo),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    bseq_order_map #(.W(OFS_W)) u_map (
        .order_sel (order_sel),
        .start_q   (start_q),
        .beat_q    (beat_q),
        .offset    (offset_o)
    );

    bseq_type_hold u_type (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .adv_ld_n (adv_ld_n),
        .wr_en_n  (wr_en_n),
        .is_wr_q  (burst_wr_o)
    );
endmodule

// File: rtl/bseq_checker.sv
// Module: property checker for burst_offset_seq, attached with bind.
module bseq_checker #(
    parameter int W = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en_n,
    input logic         adv_ld_n,
    input logic [W-1:0] addr_lo,
    input logic         order_sel,
    input logic         wr_en_n,
    input logic [W-1:0] offset_o,
    input logic         burst_wr_o
);
    // R2: a load puts the new start offset on the output at beat zero
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n) |=> (offset_o == $past(addr_lo)));

    // R3, R5: in linear order an advance adds one, with wrap
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld_n && !order_sel) |=>
        (order_sel || offset_o == W'($past(offset_o) + W'(1))));

    // R7: the access type follows the write enable sampled at a load
    a_r7_type_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld_n) |=> (burst_wr_o == !$past(wr_en_n)));

    // R6: an advance never changes the access type
    a_r6_type_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld_n) |=> $stable(burst_wr_o));

    // R8: an ignored edge changes neither the offset nor the type
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(burst_wr_o) &&
                      (order_sel != $past(order_sel) || offset_o == $past(offset_o))));
endmodule

bind burst_offset_seq bseq_checker #(.W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .adv_ld_n   (adv_ld_n),
    .addr_lo    (addr_lo),
    .order_sel  (order_sel),
    .wr_en_n    (wr_en_n),
    .offset_o   (offset_o),
    .burst_wr_o (burst_wr_o)
);

// File: tb/tb_burst_offset_seq.sv
module tb_burst_offset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en_n = 1'b1;
    logic       adv_ld_n = 1'b1;
    logic [1:0] addr_lo = 2'd0;
    logic       order_sel = 1'b0;
    logic       wr_en_n = 1'b1;
    logic [1:0] offset_o;
    logic       burst_wr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state taken from the requirements
    logic [1:0] m_start = 2'd0;
    logic [1:0] m_beat  = 2'd0;
    logic       m_wr    = 1'b0;

    always #5 clk = ~clk;

    burst_offset_seq dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n),
        .addr_lo(addr_lo), .order_sel(order_sel), .wr_en_n(wr_en_n),
        .offset_o(offset_o), .burst_wr_o(burst_wr_o)
    );

    function automatic logic [1:0] exp_ofs();
        if (order_sel) return m_start ^ m_beat;     // R4
        else           return 2'(m_start + m_beat); // R3
    endfunction

    task automatic check(string tag);
        logic [1:0] eo;
        eo = exp_ofs();
        checks++;
        if (offset_o !== eo) begin
            errors++;
            $display("FAIL %s offset: actual %0d expected %0d", tag, offset_o, eo);
        end
        checks++;
        if (burst_wr_o !== m_wr) begin
            errors++;
            $display("FAIL %s type: actual %0d expected %0d", tag, burst_wr_o, m_wr);
        end
    endtask

    // One clock: drive at the falling edge, update the model, check at the next fall
    task automatic cyc(input logic ce_n, input logic adv_n, input logic [1:0] a,
                       input logic wn, input string tag);
        clk_en_n = ce_n; adv_ld_n = adv_n; addr_lo = a; wr_en_n = wn;
        @(negedge clk);
        if (!ce_n) begin
            if (!adv_n) begin m_start = a; m_beat = 2'd0; m_wr = !wn; end
            else        m_beat = 2'(m_beat + 2'd1);
        end
        check(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 2'd3, 1'b0, "R1 after release");
    endtask

    task automatic t_linear();
        order_sel = 1'b0;
        cyc(1'b0, 1'b0, 2'd2, 1'b1, "R2 linear load");
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 2'(i), 1'b1, "R3 R5 linear advance");
    endtask

    task automatic t_interleave();
        order_sel = 1'b1;
        cyc(1'b0, 1'b0, 2'd3, 1'b0, "R7 interleaved write load");
        for (int i = 0; i < 5; i++)
            cyc(1'b0, 1'b1, 2'(i + 1), 1'(i), "R4 R5 R6 interleaved advance");
    endtask

    task automatic t_stall();
        order_sel = 1'b0;
        cyc(1'b0, 1'b0, 2'd1, 1'b1, "R2 load before stall");
        cyc(1'b0, 1'b1, 2'd0, 1'b1, "R3 step before stall");
        cyc(1'b1, 1'b0, 2'd3, 1'b0, "R8 stall with load pattern");
        cyc(1'b1, 1'b1, 2'd0, 1'b0, "R8 stall with advance pattern");
        cyc(1'b0, 1'b1, 2'd2, 1'b0, "R6 R3 step after stall");
    endtask

    task automatic t_mode_live();
        order_sel = 1'b0;
        cyc(1'b0, 1'b0, 2'd1, 1'b0, "R2 load for order switch");
        cyc(1'b0, 1'b1, 2'd1, 1'b0, "R3 beat one linear");
        order_sel = 1'b1;
        #1 check("R9 switch to interleaved");
        order_sel = 1'b0;
        #1 check("R9 switch back to linear");
    endtask

    task automatic t_reload();
        order_sel = 1'b1;
        cyc(1'b0, 1'b0, 2'd2, 1'b1, "R2 first burst");
        cyc(1'b0, 1'b1, 2'd0, 1'b1, "R4 first burst step");
        cyc(1'b0, 1'b0, 2'd0, 1'b0, "R2 R7 reload mid burst");
        cyc(1'b0, 1'b1, 2'd3, 1'b1, "R4 step after reload");
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_stall();
        t_mode_live();
        t_reload();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule